// File: doc/BRIEF.md
# Audio Overload Detector with Hold

This block watches a stereo stream of signed audio samples and drives one overload flag. A sample is over level when its magnitude is greater than seven eighths of digital full scale. Seven eighths is about 1.16 dB below the largest code. A sample on either channel can raise the flag. The flag then stays up for a minimum hold time, counted in sample periods. Every new over-level sample restarts that hold time from its full length.

Samples are looked at only in clock cycles where the sample enable is high. The enable pulses once per sample period. The hold counter also advances only on those cycles. The sample width and the hold length are parameters, and the threshold follows the sample width. A synchronous reset returns the block to idle.

Top module: `audio_overload_flag`

## Requirements
- R1: While `rst` is high, and after it is released, `overFlag` is 0 and the hold count is empty. With no over-level sample after reset, `overFlag` stays 0.
- R2: On a cycle with `sampleEn` high and an over-level sample, `overFlag` is 1 from the next cycle on.
- R3: A sample is over level when its two's-complement magnitude is strictly greater than 7·2^(SAMPLE_W−4), which is 7/8 of 2^(SAMPLE_W−1). For SAMPLE_W=16 the limit is 28672: +28672 and −28672 do not trip, while +28673 and −28673 do.
- R4: The most negative code, −2^(SAMPLE_W−1), counts as over level. No overflow occurs when its magnitude is formed.
- R5: An over-level sample on the left channel alone, or on the right channel alone, is enough to raise the flag.
- R6: After the last over-level sample, `overFlag` stays 1 through the next HOLD_LEN enabled cycles without a violation. It returns to 0 after the enabled cycle that follows them, so it stays up for HOLD_LEN+1 sample periods.
- R7: An over-level sample during the hold reloads the hold count to HOLD_LEN. This includes the enabled cycle on which the flag would otherwise drop, and there the flag stays 1.
- R8: On cycles with `sampleEn` low, the sample inputs are ignored. `overFlag` and the hold count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | One pulse per sample period; qualifies both sample inputs |
| leftSample | input | SAMPLE_W | Left channel sample, two's complement |
| rightSample | input | SAMPLE_W | Right channel sample, two's complement |
| overFlag | output | 1 | Overload flag with retriggerable hold |

## Verification
Two events can fall on the same enabled cycle: the hold count has run out and the flag is about to drop, and a fresh violation reloads the count. The bench provokes this by placing an over-level sample on exactly the HOLD_LEN+1-th clean enabled cycle after a violation. It judges the result by requiring the flag to stay high with no single-cycle gap. It then requires the full hold to run again from that point. A second collision, a violation arriving while the count is mid-decrement, is covered by retriggering a few samples into the hold. A behavioural model compares the flag on every clock.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadHold;  // restart hold count at full length
    logic decHold;   // step hold count down by one
  } holdCmd_t;
endpackage

// File: rtl/ovl_level_cmp.sv
module ovl_level_cmp #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                overLevel
);
  // 7/8 of 2^(SAMPLE_W-1) = 7 * 2^(SAMPLE_W-4)
  localparam logic [SAMPLE_W-1:0] LIMIT = {3'b111, {(SAMPLE_W-3){1'b0}}} >> 1;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] magnitude;

  // Unsigned magnitude: the most negative code maps to 2^(SAMPLE_W-1), no overflow
  always_comb begin
    if (sample[SAMPLE_W-1]) magnitude = ~sample + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    else                    magnitude = sample;
    overLevel = magnitude > LIMIT;
  end

  always_comb begin
    if (sample == MOST_NEG)
      assert_most_negative_over_R4: assert (overLevel);
  end
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HOLD_LEN = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  holdCmd_t            cmd,
  output logic                anyOver,
  output logic                holdZero
);
  localparam int CNT_W = $clog2(HOLD_LEN + 1);
  localparam logic [CNT_W-1:0] HOLD_FULL = CNT_W'(HOLD_LEN);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SAMPLE_W-1:0] chanSample [2];
  logic [1:0]          chanOver;
  logic [CNT_W-1:0]    holdCnt;

  assign chanSample[0] = leftSample;
  assign chanSample[1] = rightSample;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    ovl_level_cmp #(.SAMPLE_W(SAMPLE_W)) i_cmp (
      .sample   (chanSample[ch]),
      .overLevel(chanOver[ch])
    );
  end

  assign anyOver  = |chanOver;
  assign holdZero = (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (rst)               holdCnt <= '0;
    else if (cmd.loadHold) holdCnt <= HOLD_FULL;
    else if (cmd.decHold)  holdCnt <= holdCnt - ONE;
  end

  assert_load_full_R7: assert property (@(posedge clk) disable iff (rst)
    cmd.loadHold |=> holdCnt == HOLD_FULL);
  assert_dec_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd.decHold && !cmd.loadHold) |=> holdCnt == $past(holdCnt) - ONE);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    holdCnt <= HOLD_FULL);
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd.loadHold || cmd.decHold) |=> $stable(holdCnt));
endmodule

// File: rtl/ovl_control.sv
module ovl_control
  import ovl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sampleEn,
  input  logic     anyOver,
  input  logic     holdZero,
  output holdCmd_t cmd,
  output logic     overFlag
);
  always_comb begin
    cmd.loadHold = sampleEn && anyOver;
    cmd.decHold  = sampleEn && !anyOver && !holdZero;
  end

  always_ff @(posedge clk) begin
    if (rst)                      overFlag <= 1'b0;
    else if (cmd.loadHold)        overFlag <= 1'b1;
    else if (sampleEn && holdZero) overFlag <= 1'b0;
  end

  assert_set_on_violation_R2: assert property (@(posedge clk) disable iff (rst)
    (sampleEn && anyOver) |=> overFlag);
  assert_no_enable_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(overFlag));
  assert_drop_only_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(overFlag) |-> $past(sampleEn && holdZero && !anyOver));
  assert_flag_while_counting_R6: assert property (@(posedge clk) disable iff (rst)
    !holdZero |-> overFlag);
endmodule

// File: rtl/audio_overload_flag.sv
module audio_overload_flag #(
  parameter int SAMPLE_W = 24,
  parameter int HOLD_LEN = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleEn,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                overFlag
);
  ovl_pkg::holdCmd_t cmd;
  logic anyOver;
  logic holdZero;

  ovl_datapath #(.SAMPLE_W(SAMPLE_W), .HOLD_LEN(HOLD_LEN)) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .cmd        (cmd),
    .anyOver    (anyOver),
    .holdZero   (holdZero)
  );

  ovl_control i_control (
    .clk     (clk),
    .rst     (rst),
    .sampleEn(sampleEn),
    .anyOver (anyOver),
    .holdZero(holdZero),
    .cmd     (cmd),
    .overFlag(overFlag)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !overFlag);
endmodule

// File: tb/test_audio_overload_flag.sv
module test_audio_overload_flag;
  localparam int SW   = 16;
  localparam int HOLD = 8;
  localparam int LIM  = 28672;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleEn = 1'b0;
  logic [SW-1:0] leftSample = '0;
  logic [SW-1:0] rightSample = '0;
  logic overFlag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int  mCnt = 0;
  bit  mFlag = 0;
  bit  started = 0;

  always #5 clk = ~clk;

  audio_overload_flag #(.SAMPLE_W(SW), .HOLD_LEN(HOLD)) i_audio_overload_flag (
    .clk(clk), .rst(rst), .sampleEn(sampleEn),
    .leftSample(leftSample), .rightSample(rightSample), .overFlag(overFlag)
  );

  function automatic bit isOver(logic [SW-1:0] s);
    int v = $signed(s);
    if (v < 0) v = -v;
    return v > LIM;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mCnt = 0; mFlag = 0; started = 1;
    end else if (sampleEn) begin
      if (isOver(leftSample) || isOver(rightSample)) begin
        mCnt = HOLD; mFlag = 1;
      end else if (mCnt != 0) mCnt--;
      else mFlag = 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (overFlag !== mFlag) begin
        errors++;
        $display("FAIL %s cycle %0d: overFlag=%b expected %b", curReq, cycles, overFlag, mFlag);
      end
    end
  end

  task automatic expectFlag(string req, bit exp);
    checks++;
    if (overFlag !== exp) begin
      errors++;
      $display("FAIL %s directed: overFlag=%b expected %b", req, overFlag, exp);
    end
  endtask

  task automatic step(int l, int r, bit en);
    @(posedge clk);
    #1;
    leftSample = SW'(l); rightSample = SW'(r); sampleEn = en;
  endtask

  task automatic settle();
    @(posedge clk); #1;
    sampleEn = 1'b0; leftSample = '0; rightSample = '0;
    #3;
  endtask

  task automatic drain();
    for (int i = 0; i < HOLD + 3; i++) step(100, -100, 1);
    settle();
  endtask

  initial begin
    int lcg = 12345;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #3 expectFlag("R1", 0);
    curReq = "R1";
    for (int i = 0; i < 5; i++) step(1000, -2000, 1);
    settle(); expectFlag("R1", 0);

    curReq = "R3";
    step(LIM, -LIM, 1); settle(); expectFlag("R3", 0);
    step(LIM + 1, 0, 1); settle(); expectFlag("R3", 1);
    drain(); expectFlag("R3", 0);
    step(-(LIM + 1), 0, 1); settle(); expectFlag("R3", 1);
    drain();

    curReq = "R4";
    step(-32768, 0, 1); settle(); expectFlag("R4", 1);
    drain();

    curReq = "R5";
    step(0, 32767, 1); settle(); expectFlag("R5", 1);
    drain();
    step(-30000, 5, 1); settle(); expectFlag("R5", 1);
    drain();

    curReq = "R6";
    step(31000, 0, 1);
    for (int i = 0; i < HOLD; i++) step(0, 0, 1);
    settle(); expectFlag("R6", 1);
    step(0, 0, 1); settle(); expectFlag("R6", 0);

    curReq = "R7";
    step(31000, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    step(0, 31000, 1);
    for (int i = 0; i < HOLD; i++) step(0, 0, 1);
    settle(); expectFlag("R7", 1);
    step(31000, 0, 1);
    for (int i = 0; i < HOLD; i++) step(0, 0, 1);
    step(-31000, 0, 1);
    settle(); expectFlag("R7", 1);
    for (int i = 0; i < HOLD; i++) step(0, 0, 1);
    settle(); expectFlag("R7", 1);
    step(0, 0, 1); settle(); expectFlag("R7", 0);

    curReq = "R8";
    for (int i = 0; i < 6; i++) step(-32768, 32767, 0);
    settle(); expectFlag("R8", 0);
    step(32000, 0, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    for (int i = 0; i < HOLD; i++) step(0, 0, 1);
    settle(); expectFlag("R8", 1);
    step(0, 0, 1); settle(); expectFlag("R8", 0);

    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      step((lcg >>> 8) % 31000, (lcg >>> 4) % 29500, (lcg & 3) != 0);
    end
    settle();

    curReq = "R1";
    rst = 1'b1;
    step(-32768, 0, 1);
    settle(); expectFlag("R1", 0);
    rst = 1'b0;
    settle(); expectFlag("R1", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule